// File: doc/BRIEF.md
# Serial slave front end with transfer pause

This block is the bit-level serial front end of a mode-0 serial slave that runs on a fast system clock. SCK, chip select, HOLD and SI are brought into the system clock domain through a synchroniser chain. SCK and chip select are then edge-detected. SI is shifted into a receive register, most significant bit first, on each rising SCK edge. After the eighth rising edge the finished byte goes to the core with a one-cycle valid strobe. The first byte after chip select falls carries a flag marking it as the instruction byte.

For the outbound direction, the core supplies a byte on `tx_byte_i`. The block samples it in two places: when chip select falls, and on the falling SCK edge that follows each completed byte. It then shifts the byte out on SO, which changes only after falling SCK edges. SO is qualified by an output-enable that stays low while chip select is high and while the transfer is paused. The pad drives SO to high impedance when the enable is low.

The HOLD input pauses a transfer without losing bit position. The pause is entered or left only while SCK is low. While it lasts, SCK edges and SI are ignored. A HOLD change that happens while SCK is high takes effect at the next low SCK level. Chip select going high ends the transaction, clears any pause and drops any partially received byte. SCK must run slower than a quarter of the system clock.

Top module: `spi_hold_front`

## Requirements
- R1: SI is captured on each rising SCK edge, MSB first. After every eighth rising edge of a transaction, `rx_valid_o` is high for exactly one system cycle, and `rx_byte_o` then holds the eight captured bits in arrival order, with the first bit in bit 7.
- R2: `so_o` changes only after a falling SCK edge. It does not change after a rising edge. For bit j (0 = first) of byte k of a transaction, SO carries bit 7-j of the transmit byte that belongs to byte k. The transmit byte for byte k>0 is sampled from `tx_byte_i` on the falling SCK edge right after byte k-1 completes.
- R3: While chip select is high, `so_oe_o` is low and no `rx_valid_o` strobe occurs, whatever SCK and SI do.
- R4: Each falling chip-select edge gives one single-cycle `start_o` pulse. Each rising chip-select edge gives one single-cycle `end_o` pulse. `rx_first_o` is 1 with the first strobed byte of a transaction and 0 with every later one.
- R5: A pause begins only when HOLD is low while SCK is low. From then on `so_oe_o` is low.
- R6: A pause ends only when HOLD is high while SCK is low. After it ends, `so_oe_o` is high again while chip select stays low.
- R7: During a pause, SCK edges and SI changes have no effect. The transfer resumes at the same bit, both in the received byte and on SO.
- R8: Chip select rising part-way through a byte discards the partial byte, so no strobe occurs. The next transaction starts at bit 0.
- R9: A HOLD change made while SCK is high does not affect the pause state until SCK next goes low.
- R10: Byte 0 of a transaction is sampled from `tx_byte_i` when chip select falls. Its MSB is on `so_o` before the first rising SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock, asynchronous |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| hold_ni | input | 1 | Pause request, active low, asynchronous |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for SO; low means high impedance |
| tx_byte_i | input | BYTE_W | Byte to transmit, sampled at byte boundaries |
| rx_byte_o | output | BYTE_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_first_o | output | 1 | Strobed byte is the first of its transaction |
| start_o | output | 1 | Transaction start pulse |
| end_o | output | 1 | Transaction end pulse |

## Verification
The bench uses the defaults: an 8-bit byte and a two-stage synchroniser. With these, one transaction carrying all 256 byte values covers every receive pattern. In the same transaction, a computed transmit sequence is checked bit by bit on SO. Short transactions then cover a pause entered and left with SCK low, SCK toggling during a pause, and HOLD changes made while SCK is high. They also cover a chip-select abort mid-byte and toggling SCK while deselected. SCK runs at eight system cycles per period, so every synchroniser delay lands well inside one SCK phase.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;
  localparam int unsigned SPI_BYTE_W = 8;

  typedef struct packed {
    logic hold_n;
    logic cs_n;
    logic sck;
    logic si;
  } pins_t;

  localparam pins_t PINS_IDLE = '{hold_n: 1'b1, cs_n: 1'b1, sck: 1'b0, si: 1'b0};
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned WIDTH   = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] lvl_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg <= {STAGES{RST_VAL}};
    else         stg <= {stg[STAGES-2:0], d_i};
  end

  assign lvl_o = stg[STAGES-1];
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic sck_lvl_i,
  input  logic hold_n_i,
  output logic paused_o
);
  // pause state only moves while SCK is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         paused_o <= 1'b0;
    else if (!active_i)  paused_o <= 1'b0;
    else if (!sck_lvl_i) paused_o <= !hold_n_i;
  end

  // R5
  pause_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(paused_o) |-> $past(!sck_lvl_i && !hold_n_i));
  // R6
  pause_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(paused_o) |-> $past(!sck_lvl_i || !active_i));
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              start_i,
  input  logic              paused_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              si_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              rx_first_o,
  output logic              so_o
);
  localparam int unsigned CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [CW-1:0]     bit_cnt;
  logic [BYTE_W-1:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr;
  logic              first_pend;
  logic [BYTE_W-1:0] rx_next;

  assign rx_next = {rx_sr[BYTE_W-2:0], si_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt    <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      first_pend <= 1'b0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
      rx_first_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (!active_i) begin
        bit_cnt    <= '0;
        first_pend <= 1'b0;
      end else if (start_i) begin
        bit_cnt    <= '0;
        first_pend <= 1'b1;
        tx_sr      <= tx_byte_i;
      end else if (!paused_i) begin
        if (sck_rise_i) begin
          rx_sr <= rx_next;
          if (bit_cnt == LAST) begin
            bit_cnt    <= '0;
            rx_byte_o  <= rx_next;
            rx_valid_o <= 1'b1;
            rx_first_o <= first_pend;
            first_pend <= 1'b0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        if (sck_fall_i) begin
          // byte boundary: fetch next outbound byte
          if (bit_cnt == '0) tx_sr <= tx_byte_i;
          else               tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign so_o = tx_sr[BYTE_W-1];

  // R1
  rx_strobe_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(sck_rise_i && active_i && !paused_i));
  // R1
  rx_strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  // R2
  so_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(so_o) |-> $past(sck_fall_i || start_i));
  // R7
  pause_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused_i && active_i && !start_i) |=> ($stable(bit_cnt) && $stable(tx_sr)));
  // R8
  drop_partial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (bit_cnt == '0));
endmodule

// File: rtl/spi_hold_front.sv
module spi_hold_front
  import spi_front_pkg::*;
#(
  parameter int unsigned BYTE_W      = SPI_BYTE_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              hold_ni,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              rx_first_o,
  output logic              start_o,
  output logic              end_o
);
  localparam int unsigned PW = $bits(pins_t);

  pins_t raw_pins, pins;
  logic  sck_d, cs_d;
  logic  sck_rise, sck_fall, cs_fall, cs_rise;
  logic  active, paused;

  assign raw_pins = '{hold_n: hold_ni, cs_n: cs_ni, sck: sck_i, si: si_i};

  spi_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (PW),
    .RST_VAL(PW'(PINS_IDLE))
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_pins),
    .lvl_o (pins)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d   <= 1'b0;
      cs_d    <= 1'b1;
      start_o <= 1'b0;
      end_o   <= 1'b0;
    end else begin
      sck_d   <= pins.sck;
      cs_d    <= pins.cs_n;
      start_o <= cs_fall;
      end_o   <= cs_rise;
    end
  end

  assign sck_rise = pins.sck & ~sck_d;
  assign sck_fall = ~pins.sck & sck_d;
  assign cs_fall  = cs_d & ~pins.cs_n;
  assign cs_rise  = ~cs_d & pins.cs_n;
  assign active   = ~pins.cs_n;

  spi_hold_fsm u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .sck_lvl_i(pins.sck),
    .hold_n_i (pins.hold_n),
    .paused_o (paused)
  );

  spi_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .start_i   (cs_fall),
    .paused_i  (paused),
    .sck_rise_i(sck_rise),
    .sck_fall_i(sck_fall),
    .si_i      (pins.si),
    .tx_byte_i (tx_byte_i),
    .rx_byte_o (rx_byte_o),
    .rx_valid_o(rx_valid_o),
    .rx_first_o(rx_first_o),
    .so_o      (so_o)
  );

  assign so_oe_o = active & ~paused;

  // R3
  idle_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(active));
  // R4
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R4
  end_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !end_o);
endmodule

// File: tb/sim_spi_hold_front.sv
module sim_spi_hold_front;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
  logic [7:0] tx_val = '0;
  logic so, so_oe, rx_valid, rx_first, start_p, end_p;
  logic [7:0] rx_byte;

  always #4 clk = ~clk;

  spi_hold_front u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .cs_ni(cs_n), .hold_ni(hold_n),
    .si_i(si), .so_o(so), .so_oe_o(so_oe), .tx_byte_i(tx_val),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .rx_first_o(rx_first),
    .start_o(start_p), .end_o(end_p)
  );

  int n_chk = 0, n_bad = 0;
  int rx_total = 0, exp_n = 0, byte_k = 0, n_start = 0, n_end = 0;
  logic [7:0] exp_rx [0:511];
  logic       exp_first [0:511];
  bit done = 0;

  function automatic logic [7:0] tfun(int k);
    return 8'((k * 29 + 11) & 255);
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      if (start_p) begin n_start++; byte_k = 0; end
      if (end_p) n_end++;
      if (rx_valid) begin
        chk(rx_byte == exp_rx[rx_total], "R1 rx byte", int'(rx_byte), int'(exp_rx[rx_total]));
        chk(rx_first == exp_first[rx_total], "R4 first flag", int'(rx_first), int'(exp_first[rx_total]));
        rx_total++;
        byte_k++;
        tx_val = tfun(byte_k);
      end
    end
  end

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b, logic ex, bit dochk, string req);
    si = b;
    wt(4);
    if (dochk) chk(so_oe && so == ex, req, int'({so_oe, so}), int'({1'b1, ex}));
    sck = 1'b1;
    wt(4);
    sck = 1'b0;
  endtask

  task automatic push_exp(logic [7:0] d, int k);
    exp_rx[exp_n] = d;
    exp_first[exp_n] = (k == 0);
    exp_n++;
  endtask

  task automatic send_bits(logic [7:0] d, int k, int lo, int hi);
    logic [7:0] t;
    t = tfun(k);
    for (int j = lo; j <= hi; j++)
      send_bit(d[7-j], t[7-j], 1'b1, (k == 0 && j == 0) ? "R10 first MSB" : "R2 so bit");
  endtask

  task automatic begin_txn();
    tx_val = tfun(0);
    cs_n = 1'b0;
    wt(6);
  endtask

  task automatic end_txn();
    wt(4);
    cs_n = 1'b1;
    wt(6);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] t;
    wt(5);
    rst_ni = 1'b1;
    wt(3);
    // R3 reset state
    chk(!so_oe, "R3 reset oe", int'(so_oe), 0);
    chk(!rx_valid && !start_p && !end_p, "R4 reset pulses", int'({rx_valid, start_p, end_p}), 0);

    // full byte sweep in one transaction
    begin_txn();
    for (int k = 0; k < 256; k++) begin
      push_exp(8'(k), k);
      send_bits(8'(k), k, 0, 7);
    end
    end_txn();

    // pause tests
    begin_txn();
    push_exp(8'hA5, 0);
    send_bits(8'hA5, 0, 0, 7);
    // pause entered and left with SCK low, SCK and SI toggled inside
    push_exp(8'h3C, 1);
    send_bits(8'h3C, 1, 0, 3);
    hold_n = 1'b0;
    wt(4);
    chk(!so_oe, "R5 pause oe", int'(so_oe), 0);
    for (int i = 0; i < 3; i++) begin
      si = ~si; sck = 1'b1; wt(4);
      si = ~si; sck = 1'b0; wt(4);
    end
    hold_n = 1'b1;
    wt(4);
    chk(so_oe, "R6 resume oe", int'(so_oe), 1);
    send_bits(8'h3C, 1, 4, 7);   // R7 position kept
    // HOLD changes while SCK high
    push_exp(8'hC3, 2);
    send_bits(8'hC3, 2, 0, 1);
    t = tfun(2);
    si = 1'b0;
    wt(4);
    chk(so_oe && so == t[5], "R2 so bit", int'(so), int'(t[5]));
    sck = 1'b1;
    hold_n = 1'b0;
    wt(4);
    chk(so_oe, "R9 entry deferred", int'(so_oe), 1);
    sck = 1'b0;
    wt(4);
    chk(!so_oe, "R5 entry at low", int'(so_oe), 0);
    sck = 1'b1;
    wt(2);
    hold_n = 1'b1;
    wt(4);
    chk(!so_oe, "R9 exit deferred", int'(so_oe), 0);
    sck = 1'b0;
    wt(4);
    chk(so_oe, "R6 exit at low", int'(so_oe), 1);
    send_bits(8'hC3, 2, 3, 7);   // R7 ignored edges left no trace
    push_exp(8'h96, 3);
    send_bits(8'h96, 3, 0, 7);
    end_txn();

    // R8 abort mid-byte
    begin_txn();
    for (int j = 0; j < 5; j++) send_bit(1'b1, 1'b0, 1'b0, "R8");
    end_txn();
    chk(rx_total == exp_n, "R8 partial dropped", rx_total, exp_n);
    begin_txn();
    push_exp(8'h5A, 0);
    send_bits(8'h5A, 0, 0, 7);
    end_txn();

    // R3 deselected activity
    for (int j = 0; j < 16; j++) begin
      send_bit(j[0], 1'b0, 1'b0, "R3");
      chk(!so_oe, "R3 idle oe", int'(so_oe), 0);
    end
    wt(6);
    chk(rx_total == exp_n, "R3 no strobe idle", rx_total, exp_n);
    chk(n_start == 4, "R4 start count", n_start, 4);
    chk(n_end == 4, "R4 end count", n_end, 4);
    finish_run();
  end
endmodule